// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers interrupt requests from 128 sources and chooses one of them for the processor. Each source has a priority from 0 to 15 that software writes. Priority 0 turns the source off. The highest priority among pending sources wins. When several sources share that priority, the lowest source index wins. A single registered request line goes to the processor, together with a 9-bit vector that names the winning source. The request is raised only when the winner's priority is strictly above a current-priority register that software can write.

Sources 0 to 7 have no peripheral line; register writes set and clear them. A handler can therefore hand the rest of its work to a lower-priority software source. Peripheral sources 8 to 127 come from level-sensitive input lines. When the processor acknowledges a request, the block pushes the current priority onto a 16-deep stack and loads the winner's priority in its place. An end-of-interrupt pops the stack. Writing the current priority directly lets software raise a ceiling over a shared resource.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source s in 8..127 is pending exactly while input line `periphIrq[s-8]` is high. The line is level-sensitive and nothing is latched.
- R2: While `irqOut` is high, `vecOut` equals the winning source index zero-extended to 9 bits.
- R3: A write to address 0x88+k (k = 0..7) with `busWdata[0]`=1 makes software source k pending. A write with bit 0 = 0 clears it. The source stays pending until software clears it. Reading that address returns the flag in bit 0.
- R4: Address i (0..127) holds the 4-bit priority of source i in `busWdata[3:0]`. It resets to 0 and reads back what was written.
- R5: A source whose priority is 0 never causes `irqOut` to rise.
- R6: Among pending sources the highest priority wins. On a tie the lowest source index wins.
- R7: `irqOut` rises only when the winner's priority is strictly greater than the current priority. The current priority is at address 0x80, bits [3:0], and resets to 0. An equal priority is masked.
- R8: A change on a request line, or in a priority register, shows on `irqOut` at the second rising clock edge after the change.
- R9: An `intAck` sampled while `irqOut` is high does three things: it pushes the current priority, it loads the winner's priority as the new current priority, and it drives `irqOut` low at that same edge.
- R10: An `intEoi` pops the stack back into the current priority. An `intEoi` with an empty stack leaves the current priority unchanged.
- R11: An `intAck` sampled while `irqOut` is low changes neither the current priority nor the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| periphIrq | input | 120 | Level request lines for sources 8..127 |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register address |
| busWdata | input | 4 | Register write data |
| busRdata | output | 4 | Register read data (combinational on address) |
| intAck | input | 1 | Processor acknowledge |
| intEoi | input | 1 | Processor end-of-interrupt |
| irqOut | output | 1 | Registered interrupt request to the processor |
| vecOut | output | 9 | Registered vector of the winning source |

## Verification
The assertions assume three things about the inputs:
- `intAck` is a single-cycle pulse that means something only while `irqOut` is high.
- `intEoi` is never raised in the same cycle as `intAck`.
- No bus write to the current priority lands in the same cycle as an acknowledge or end-of-interrupt.

The stimulus keeps to these rules. It drives every strobe for exactly one cycle between falling edges and issues acknowledges only after the request has had time to settle. It waits at least four cycles after any bus write or line change before it samples, except in the latency scenario, which counts edges exactly.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SRC     = 128;
  localparam int NUM_SW      = 8;
  localparam int PRIO_W      = 4;
  localparam int VEC_W       = 9;
  localparam int STACK_DEPTH = 16;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = PRIO_W;
  localparam int NUM_PER     = NUM_SRC - NUM_SW;
  localparam int IDX_W       = $clog2(NUM_SRC);
  localparam int SW_W        = $clog2(NUM_SW);
  localparam int SLOT_W      = $clog2(STACK_DEPTH);
  localparam int SP_W        = $clog2(STACK_DEPTH + 1);
  localparam int CUR_ADDR    = NUM_SRC;
  localparam int SW_BASE     = NUM_SRC + 8;

  typedef struct packed {
    logic              prioWe;
    logic              curWe;
    logic              swWe;
    logic              push;
    logic              pop;
    logic [IDX_W-1:0]  idx;
    logic [SW_W-1:0]   swIdx;
    logic [PRIO_W-1:0] val;
    logic              swVal;
    logic [SLOT_W-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [NUM_PER-1:0] periphIrq,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic [PRIO_W-1:0]  curPrio,
  output logic [PRIO_W-1:0]  reqPrio
);
  logic [PRIO_W-1:0]  prioReg  [NUM_SRC];
  logic [PRIO_W-1:0]  effPrio  [NUM_SRC];
  logic [PRIO_W-1:0]  stackMem [STACK_DEPTH];
  logic [NUM_SW-1:0]  swFlag;
  logic [NUM_SRC-1:0] pending;
  logic [IDX_W-1:0]   bestIdx, winIdx;
  logic [PRIO_W-1:0]  bestPrio, winPrio;

  assign pending = {periphIrq, swFlag};

  // Per-source priority storage and masking by pending state
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN)                                    prioReg[i] <= '0;
      else if (st.prioWe && st.idx == IDX_W'(i))    prioReg[i] <= st.val;
    end
    assign effPrio[i] = pending[i] ? prioReg[i] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) swFlag <= '0;
    else if (st.swWe) swFlag[st.swIdx] <= st.swVal;
  end

  // Highest priority wins; scanning downward with >= leaves the lowest index on ties
  always_comb begin
    bestPrio = '0;
    bestIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (effPrio[i] != '0 && effPrio[i] >= bestPrio) begin
        bestPrio = effPrio[i];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  // Stage 1: arbitration result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winIdx  <= '0;
      winPrio <= '0;
    end else begin
      winIdx  <= bestIdx;
      winPrio <= bestPrio;
    end
  end

  // Stage 2: masked request towards the processor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      vecOut  <= '0;
      reqPrio <= '0;
    end else begin
      irqOut  <= !st.push && (winPrio > curPrio);
      vecOut  <= VEC_W'(winIdx);
      reqPrio <= winPrio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          curPrio <= '0;
    else if (st.push)   curPrio <= reqPrio;
    else if (st.pop)    curPrio <= stackMem[st.slot];
    else if (st.curWe)  curPrio <= st.val;
  end

  always_ff @(posedge clk) begin
    if (st.push) stackMem[st.slot] <= curPrio;
  end

  always_comb begin
    busRdata = '0;
    if (int'(busAddr) < NUM_SRC)
      busRdata = prioReg[busAddr[IDX_W-1:0]];
    else if (int'(busAddr) == CUR_ADDR)
      busRdata = curPrio;
    else if (int'(busAddr) >= SW_BASE && int'(busAddr) < SW_BASE + NUM_SW)
      busRdata = DATA_W'(swFlag[SW_W'(int'(busAddr) - SW_BASE)]);
  end
endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              intAck,
  input  logic              intEoi,
  input  logic              irqOut,
  output strobe_t           st,
  output logic [SP_W-1:0]   stackPtr
);
  logic push, pop;
  logic inSw;

  assign push = intAck && irqOut && (stackPtr != SP_W'(STACK_DEPTH));
  assign pop  = intEoi && !push && (stackPtr != '0);
  assign inSw = (int'(busAddr) >= SW_BASE) && (int'(busAddr) < SW_BASE + NUM_SW);

  always_ff @(posedge clk) begin
    if (!rstN)     stackPtr <= '0;
    else if (push) stackPtr <= stackPtr + 1'b1;
    else if (pop)  stackPtr <= stackPtr - 1'b1;
  end

  always_comb begin
    st.prioWe = busWe && (int'(busAddr) < NUM_SRC);
    st.curWe  = busWe && (int'(busAddr) == CUR_ADDR);
    st.swWe   = busWe && inSw;
    st.push   = push;
    st.pop    = pop;
    st.idx    = busAddr[IDX_W-1:0];
    st.swIdx  = SW_W'(int'(busAddr) - SW_BASE);
    st.val    = busWdata[PRIO_W-1:0];
    st.swVal  = busWdata[0];
    st.slot   = push ? stackPtr[SLOT_W-1:0] : SLOT_W'(stackPtr - 1'b1);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PER-1:0] periphIrq,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               intAck,
  input  logic               intEoi,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut
);
  strobe_t           st;
  logic [PRIO_W-1:0] curPrio;
  logic [PRIO_W-1:0] reqPrio;
  logic [SP_W-1:0]   stackPtr;

  pic_control i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .intAck   (intAck),
    .intEoi   (intEoi),
    .irqOut   (irqOut),
    .st       (st),
    .stackPtr (stackPtr)
  );

  pic_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .periphIrq (periphIrq),
    .busAddr   (busAddr),
    .busRdata  (busRdata),
    .irqOut    (irqOut),
    .vecOut    (vecOut),
    .curPrio   (curPrio),
    .reqPrio   (reqPrio)
  );
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              intAck,
  input logic              intEoi,
  input logic              irqOut,
  input logic [PRIO_W-1:0] curPrio,
  input logic [PRIO_W-1:0] reqPrio,
  input logic [SP_W-1:0]   stackPtr
);
  // R5
  zero_prio_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> reqPrio != '0);

  // R9
  ack_loads_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && irqOut && stackPtr != SP_W'(STACK_DEPTH)) |=> curPrio == $past(reqPrio));

  // R9
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && irqOut && stackPtr != SP_W'(STACK_DEPTH)) |=> !irqOut);

  // R10
  eoi_pops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEoi && !intAck && stackPtr != '0) |=> stackPtr == $past(stackPtr) - 1'b1);

  // R10
  eoi_empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEoi && !intAck && stackPtr == '0 && !(busWe && int'(busAddr) == CUR_ADDR))
      |=> $stable(curPrio));

  // R11
  ack_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !irqOut && !intEoi) |=> $stable(stackPtr));

  // R9
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackPtr <= SP_W'(STACK_DEPTH));
endmodule

bind prio_irq_ctrl pic_checker u_pic_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .intAck   (intAck),
  .intEoi   (intEoi),
  .irqOut   (irqOut),
  .curPrio  (curPrio),
  .reqPrio  (reqPrio),
  .stackPtr (stackPtr)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  import pic_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN;
  logic [NUM_SRC-1:0] srcLines;
  logic               busWe;
  logic [ADDR_W-1:0]  busAddr;
  logic [DATA_W-1:0]  busWdata;
  logic [DATA_W-1:0]  busRdata;
  logic               intAck, intEoi;
  logic               irqOut;
  logic [VEC_W-1:0]   vecOut;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .periphIrq (srcLines[NUM_SRC-1:NUM_SW]),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .intAck    (intAck),
    .intEoi    (intEoi),
    .irqOut    (irqOut),
    .vecOut    (vecOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic busWr(input int addr, input int val);
    @(negedge clk);
    busWe = 1'b1; busAddr = ADDR_W'(addr); busWdata = DATA_W'(val);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRd(input int addr, output int val);
    busAddr = ADDR_W'(addr);
    #1;
    val = int'(busRdata);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseAck();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic pulseEoi();
    @(negedge clk); intEoi = 1'b1;
    @(negedge clk); intEoi = 1'b0;
  endtask

  task automatic testReset();
    int v;
    check("R7", "irqOut after reset", int'(irqOut), 0);
    busRd(CUR_ADDR, v);     check("R7", "current priority after reset", v, 0);
    busRd(5, v);            check("R4", "priority of source 5 after reset", v, 0);
    busRd(SW_BASE + 2, v);  check("R3", "software flag 2 after reset", v, 0);
  endtask

  task automatic testPrioRegs();
    int v;
    busWr(77, 11);
    busWr(0, 15);
    busRd(77, v); check("R4", "read back source 77", v, 11);
    busRd(0, v);  check("R4", "read back source 0", v, 15);
    busWr(77, 0);
    busWr(0, 0);
  endtask

  task automatic testSoftware();
    int v;
    busWr(3, 4);
    busWr(SW_BASE + 3, 1);
    settle();
    check("R3", "irqOut with software source 3 set", int'(irqOut), 1);
    check("R2", "vector for source 3", int'(vecOut), 3);
    busRd(SW_BASE + 3, v); check("R3", "software flag 3 read", v, 1);
    repeat (10) @(negedge clk);
    check("R3", "software source still pending", int'(irqOut), 1);
    busWr(SW_BASE + 3, 0);
    settle();
    check("R3", "irqOut after software clear", int'(irqOut), 0);
    busRd(SW_BASE + 3, v); check("R3", "software flag 3 cleared", v, 0);
    busWr(3, 0);
  endtask

  task automatic testPrioZero();
    srcLines[50] = 1'b1;
    settle();
    check("R5", "pending source with priority 0", int'(irqOut), 0);
    busWr(50, 2);
    settle();
    check("R5", "same source after priority 2", int'(irqOut), 1);
    check("R2", "vector for source 50", int'(vecOut), 50);
    srcLines[50] = 1'b0;
    busWr(50, 0);
    settle();
  endtask

  task automatic testArbitration();
    busWr(60, 7); busWr(70, 7); busWr(100, 3);
    srcLines[60] = 1'b1; srcLines[70] = 1'b1; srcLines[100] = 1'b1;
    settle();
    check("R6", "tie at priority 7 picks lower index", int'(vecOut), 60);
    busWr(70, 9);
    settle();
    check("R6", "higher priority wins over lower index", int'(vecOut), 70);
    srcLines[60] = 1'b0; srcLines[70] = 1'b0;
    settle();
    check("R6", "only remaining source wins", int'(vecOut), 100);
    srcLines[100] = 1'b0;
    busWr(60, 0); busWr(70, 0); busWr(100, 0);
    settle();
  endtask

  task automatic testMask();
    busWr(30, 6);
    busWr(CUR_ADDR, 6);
    srcLines[30] = 1'b1;
    settle();
    check("R7", "equal priority is masked", int'(irqOut), 0);
    busWr(CUR_ADDR, 5);
    settle();
    check("R7", "priority above mask raises request", int'(irqOut), 1);
    check("R2", "vector for source 30", int'(vecOut), 30);
    srcLines[30] = 1'b0;
    busWr(CUR_ADDR, 0);
    busWr(30, 0);
    settle();
  endtask

  task automatic testLatency();
    busWr(90, 3);
    settle();
    @(negedge clk); srcLines[90] = 1'b1;
    @(negedge clk);
    check("R8", "one edge after line rise", int'(irqOut), 0);
    @(negedge clk);
    check("R8", "two edges after line rise", int'(irqOut), 1);
    srcLines[90] = 1'b0;
    @(negedge clk);
    check("R8", "one edge after line fall", int'(irqOut), 1);
    @(negedge clk);
    check("R8", "two edges after line fall", int'(irqOut), 0);
    busWr(90, 0);
  endtask

  task automatic testNesting();
    int v;
    busWr(20, 5); busWr(40, 9);
    srcLines[20] = 1'b1;
    settle();
    check("R2", "vector before first ack", int'(vecOut), 20);
    pulseAck();
    check("R9", "irqOut low after ack", int'(irqOut), 0);
    busRd(CUR_ADDR, v); check("R9", "current priority after first ack", v, 5);
    srcLines[40] = 1'b1;
    settle();
    check("R9", "nested request preempts", int'(irqOut), 1);
    check("R2", "nested vector", int'(vecOut), 40);
    pulseAck();
    busRd(CUR_ADDR, v); check("R9", "current priority after nested ack", v, 9);
    pulseEoi();
    busRd(CUR_ADDR, v); check("R10", "first end-of-interrupt restores 5", v, 5);
    pulseEoi();
    busRd(CUR_ADDR, v); check("R10", "second end-of-interrupt restores 0", v, 0);
    srcLines[20] = 1'b0; srcLines[40] = 1'b0;
    settle();
    pulseEoi();
    busRd(CUR_ADDR, v); check("R10", "end-of-interrupt on empty stack", v, 0);
    busWr(20, 0); busWr(40, 0);
  endtask

  task automatic testIdleAck();
    int v;
    busWr(CUR_ADDR, 2);
    settle();
    pulseAck();
    busRd(CUR_ADDR, v); check("R11", "ack with no request keeps priority", v, 2);
    pulseEoi();
    busRd(CUR_ADDR, v); check("R11", "no stack entry from idle ack", v, 2);
    busWr(CUR_ADDR, 0);
  endtask

  task automatic testLevel();
    busWr(8, 1); busWr(127, 1);
    srcLines[8] = 1'b1; srcLines[127] = 1'b1;
    settle();
    check("R1", "first peripheral source wins tie", int'(vecOut), 8);
    srcLines[8] = 1'b0;
    settle();
    check("R1", "last peripheral source after drop", int'(vecOut), 127);
    srcLines[127] = 1'b0;
    settle();
    check("R1", "no request once lines fall", int'(irqOut), 0);
    busWr(8, 0); busWr(127, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; srcLines = '0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    intAck = 1'b0; intEoi = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrioRegs();
    testSoftware();
    testPrioZero();
    testArbitration();
    testMask();
    testLatency();
    testNesting();
    testIdleAck();
    testLevel();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule